// File: doc/BRIEF.md
# Serial Register Slave with Active-High Select

This block lets an external host reach a 128-entry, 8-bit register space over a four-wire serial link. It also reaches one FIFO data port and one 16-bit status value through the same link. The select line is active high. Every access opens with a header byte: a direction flag followed by a 7-bit address. Any number of data bytes follow while select stays high. After each data byte the address steps to the next location. The one exception is the FIFO port address, which holds still so that a burst streams through the FIFO.

The serial output is released to high impedance whenever read data is not being shifted. A host can therefore join SDI and SDO on a single wire. The 16-bit status value stays consistent inside one access: reading its low byte freezes the high byte in a shadow register. Words cut off by a drop of select are thrown away.

The link signals are synchronised into the system clock domain and both SCK edges are detected there. Each SCK half period must last at least five system clock cycles.

Top module: `spi_regslave`

## Requirements
- R1: While `spi_sel` is low the slave is idle. SCK and SDI are ignored, no register write, FIFO push or FIFO pop happens, and `spi_sdo_oe` is 0 (SDO high impedance).
- R2: The first byte after `spi_sel` rises is a header, shifted MSB first. Bit 7 gives the direction (0 = write, 1 = read) and bits 6:0 give the start address.
- R3: `spi_sdo_oe` is 1 only while read data bytes are being shifted out. It is 0 during the header and during write data bytes. Read data leaves MSB first.
- R4: Address `FIFO_ADDR` (default 0x7E) is the FIFO port and does not advance. Each complete written byte gives one `fifo_push` pulse carrying that byte. Each read byte gives one `fifo_pop` pulse after its first bit has been clocked out, and that byte carries the `fifo_rdata` value present before the pop.
- R5: Every other address advances by one after each data byte in the same access, wrapping from 0x7F to 0x00. Written bytes read back unchanged.
- R6: SDI is sampled on the rising SCK edge. SDO changes only after a falling SCK edge and is stable while SCK is high.
- R7: Reading address 0x10 returns `stat_val[7:0]` and captures `stat_val[15:8]` into a shadow register. Reading 0x11 returns the shadow, not the live value. Writes to 0x10 and 0x11 are ignored.
- R8: A byte cut short by a drop of `spi_sel` is discarded and writes nothing.
- R9: After reset `spi_sdo_oe`, `fifo_push` and `fifo_pop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sel | input | 1 | Slave select, active high |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host, high impedance when not driving |
| spi_sdo_oe | output | 1 | High while `spi_sdo` is driven |
| fifo_push | output | 1 | One-cycle push strobe for the FIFO port |
| fifo_wdata | output | 8 | Byte carried by `fifo_push` |
| fifo_pop | output | 1 | One-cycle pop strobe for the FIFO port |
| fifo_rdata | input | 8 | Head byte of the FIFO, shown before a pop |
| stat_val | input | 16 | Live 16-bit status value |

## Verification
The bench targets the ends of a burst. An extra prefetch at the closing SCK fall would show up as one pop too many on a FIFO read. A burst through 0x7F checks that the address wraps to 0x00 instead of stopping there. To test the status pair, the live status is changed partway through an access. A design that reads the high byte live, or that fills the shadow at the wrong moment, returns the new high byte instead of the frozen one. Other stimulus covers toggling SCK with select low, aborting a write mid-byte, and writing to the read-only status addresses. A design that leaks clocks through a low select, commits partial bytes, or overwrites the status would corrupt a register that is read back later.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  typedef enum logic [1:0] {
    AK_REG  = 2'd0,
    AK_FIFO = 2'd1,
    AK_STLO = 2'd2,
    AK_STHI = 2'd3
  } addr_kind_e;
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[g] <= '0;
        else     st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= '0;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_rs_regfile.sv
module spi_rs_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_rs_engine.sv
module spi_rs_engine #(
  parameter int               ADDR_W    = 7,
  parameter int               DATA_W    = 8,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 7'h7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] load_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              load_now,
  output logic              rd_commit,
  output logic              sdo_bit,
  output logic              sdo_oe
);
  localparam int              CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_q, rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] sh_in;
  logic [DATA_W-1:0] sh_out, byte_w;
  logic              in_data, is_read, load_pend;
  logic [ADDR_W-1:0] nxt_addr;

  assign rise      = sck & ~sck_q;
  assign fall      = ~sck & sck_q;
  assign byte_w    = {sh_in, sdi};
  assign nxt_addr  = (cur_addr == FIFO_ADDR) ? cur_addr : cur_addr + 1'b1;
  assign load_now  = sel & fall & load_pend;
  assign rd_commit = sel & rise & in_data & is_read & (bit_cnt == '0);
  assign sdo_bit   = sh_out[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck;
  end

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst || !sel) begin
      bit_cnt   <= '0;
      in_data   <= 1'b0;
      is_read   <= 1'b0;
      load_pend <= 1'b0;
      sdo_oe    <= 1'b0;
      sh_out    <= '0;
      if (rst) begin
        cur_addr <= '0;
        sh_in    <= '0;
        wr_addr  <= '0;
        wr_data  <= '0;
      end
    end else begin
      if (rise) begin
        sh_in   <= {sh_in[DATA_W-3:0], sdi};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          if (!in_data) begin
            in_data   <= 1'b1;
            is_read   <= byte_w[DATA_W-1];
            cur_addr  <= byte_w[ADDR_W-1:0];
            load_pend <= byte_w[DATA_W-1];
          end else if (is_read) begin
            cur_addr  <= nxt_addr;
            load_pend <= 1'b1;
          end else begin
            wr_en    <= 1'b1;
            wr_addr  <= cur_addr;
            wr_data  <= byte_w;
            cur_addr <= nxt_addr;
          end
        end
      end
      if (fall) begin
        if (load_pend) begin
          sh_out    <= load_data;
          sdo_oe    <= 1'b1;
          load_pend <= 1'b0;
        end else begin
          sh_out <= {sh_out[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter int               ADDR_W       = 7,
  parameter int               DATA_W       = 8,
  parameter int               SYNC_STAGES  = 2,
  parameter logic [ADDR_W-1:0] FIFO_ADDR    = 7'h7E,
  parameter logic [ADDR_W-1:0] STAT_LO_ADDR = 7'h10,
  parameter logic [ADDR_W-1:0] STAT_HI_ADDR = 7'h11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                spi_sel,
  input  logic                spi_sck,
  input  logic                spi_sdi,
  output logic                spi_sdo,
  output logic                spi_sdo_oe,
  output logic                fifo_push,
  output logic [DATA_W-1:0]   fifo_wdata,
  output logic                fifo_pop,
  input  logic [DATA_W-1:0]   fifo_rdata,
  input  logic [2*DATA_W-1:0] stat_val
);
  logic              sel_s, sck_s, sdi_s;
  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic [DATA_W-1:0] wr_data, ram_q, load_data, stat_shadow;
  logic              wr_en, load_now, rd_commit, sdo_bit;
  addr_kind_e        cur_kind, wr_kind;

  function automatic addr_kind_e classify(input logic [ADDR_W-1:0] a);
    if (a == FIFO_ADDR)         return AK_FIFO;
    else if (a == STAT_LO_ADDR) return AK_STLO;
    else if (a == STAT_HI_ADDR) return AK_STHI;
    else                        return AK_REG;
  endfunction

  spi_rs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sel, spi_sck, spi_sdi}),
    .q   ({sel_s, sck_s, sdi_s})
  );

  spi_rs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_ADDR(FIFO_ADDR)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel_s),
    .sck       (sck_s),
    .sdi       (sdi_s),
    .load_data (load_data),
    .cur_addr  (cur_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .load_now  (load_now),
    .rd_commit (rd_commit),
    .sdo_bit   (sdo_bit),
    .sdo_oe    (spi_sdo_oe)
  );

  assign cur_kind = classify(cur_addr);
  assign wr_kind  = classify(wr_addr);

  spi_rs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .we    (wr_en && (wr_kind == AK_REG)),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (cur_addr),
    .rdata (ram_q)
  );

  always_comb begin
    case (cur_kind)
      AK_FIFO: load_data = fifo_rdata;
      AK_STLO: load_data = stat_val[DATA_W-1:0];
      AK_STHI: load_data = stat_shadow;
      default: load_data = ram_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_shadow <= '0;
      fifo_pop    <= 1'b0;
    end else begin
      fifo_pop <= rd_commit && (cur_kind == AK_FIFO);
      if (load_now && (cur_kind == AK_STLO))
        stat_shadow <= stat_val[2*DATA_W-1:DATA_W];
    end
  end

  assign fifo_push  = wr_en && (wr_kind == AK_FIFO);
  assign fifo_wdata = wr_data;
  assign spi_sdo    = spi_sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk (
  input logic clk,
  input logic rst,
  input logic sel_s,
  input logic sck_s,
  input logic spi_sdo_oe,
  input logic sdo_bit,
  input logic fifo_push,
  input logic fifo_pop
);
  logic sck_prev, fall_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      fall_d   <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      fall_d   <= sck_prev & ~sck_s;
    end
  end

  AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> !spi_sdo_oe); // R1
  AST_IDLE_NO_FIFO: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> !(fifo_push || fifo_pop)); // R1
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_push, fifo_pop})); // R4
  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
    fifo_push |=> !fifo_push); // R4
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sdo_oe) |-> fall_d); // R3
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (spi_sdo_oe && $past(spi_sdo_oe) && !fall_d) |-> $stable(sdo_bit)); // R6
endmodule

bind spi_regslave spi_regslave_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_s      (sel_s),
  .sck_s      (sck_s),
  .spi_sdo_oe (spi_sdo_oe),
  .sdo_bit    (sdo_bit),
  .fifo_push  (fifo_push),
  .fifo_pop   (fifo_pop)
);

// File: tb/tb_spi_regslave.sv
`timescale 1ns/1ps
module tb_spi_regslave;
  localparam int HALF = 5;
  localparam int NV   = 6;
  // {addr[6:0], data[7:0]}
  localparam logic [14:0] VEC [NV] = '{15'h003C, 15'h01A5, 15'h05FF,
                                      15'h2000, 15'h4081, 15'h7F5A};

  logic clk = 0, rst = 1;
  logic spi_sel = 0, spi_sck = 0, spi_sdi = 0;
  logic spi_sdo, spi_sdo_oe, fifo_push, fifo_pop;
  logic [7:0] fifo_wdata, fifo_rdata, pop_cnt;
  logic [15:0] stat_val = 16'h0000;
  logic [7:0] push_log [8];
  int push_cnt = 0, checks = 0, errors = 0, unstable = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_regslave dut (
    .clk(clk), .rst(rst), .spi_sel(spi_sel), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
    .stat_val(stat_val)
  );

  assign fifo_rdata = 8'hC0 + pop_cnt;
  always @(posedge clk) begin
    if (rst) pop_cnt <= 8'd0;
    else if (fifo_pop) pop_cnt <= pop_cnt + 8'd1;
    if (!rst && fifo_push) begin
      push_log[push_cnt[2:0]] <= fifo_wdata;
      push_cnt <= push_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx,
                       output logic oe_any, output logic oe_all);
    oe_any = 0; oe_all = 1; rx = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      spi_sdi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_sdo; oe_any |= spi_sdo_oe; oe_all &= spi_sdo_oe;
      spi_sck = 1;
      repeat (HALF) @(negedge clk);
      if (spi_sdo_oe && spi_sdo !== rx[i]) unstable++;
      spi_sck = 0;
    end
  endtask

  task automatic sel_on;
    @(negedge clk); spi_sel = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off;
    repeat (HALF) @(negedge clk);
    spi_sel = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r; logic x, y;
    sel_on; xbyte({1'b0, a}, r, x, y); xbyte(d, r, x, y); sel_off;
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d);
    logic x, y;
    sel_on; xbyte({1'b1, a}, d, x, y); xbyte(8'h00, d, x, y); sel_off;
  endtask

  initial begin
    logic [7:0] r, r2; logic oa, ol;
    repeat (5) @(negedge clk);
    chk("R9 oe during reset", spi_sdo_oe, 0);
    rst = 0;
    @(negedge clk);
    chk("R9 oe after reset", spi_sdo_oe, 0);
    chk("R9 push/pop after reset", {fifo_push, fifo_pop}, 0);

    // Vector table: write every entry, then read every entry back (R2, R5)
    for (int v = 0; v < NV; v++) wr1(VEC[v][14:8], VEC[v][7:0]);
    for (int v = 0; v < NV; v++) begin
      rd1(VEC[v][14:8], r);
      chk($sformatf("R2 readback addr %0h", VEC[v][14:8]), r, VEC[v][7:0]);
    end

    // R3: oe low in header and write data, high across read data
    sel_on;
    xbyte(8'h85, r, oa, ol); chk("R3 oe in read header", oa, 0);
    xbyte(8'h00, r, oa, ol); chk("R3 oe across read byte", ol, 1);
    chk("R3 read data 0x05", r, 8'hFF);
    sel_off;
    chk("R3 oe after deselect", spi_sdo_oe, 0);
    sel_on;
    xbyte(8'h06, r, oa, ol); xbyte(8'h44, r, oa, ol);
    chk("R3 oe in write byte", oa, 0);
    sel_off;

    // R1: activity with select low is ignored
    xbyte(8'h00, r, oa, ol); xbyte(8'h77, r, oa, ol);
    xbyte(8'h7E, r, oa, ol); xbyte(8'h99, r, oa, ol);
    chk("R1 oe with select low", oa, 0);
    chk("R1 no push with select low", push_cnt, 0);
    rd1(7'h00, r); chk("R1 reg 0x00 untouched", r, 8'h3C);

    // R8: partial write byte dropped
    sel_on;
    xbyte(8'h20, r, oa, ol);
    for (int i = 0; i < 4; i++) begin
      spi_sdi = 1; repeat (HALF) @(negedge clk); spi_sck = 1;
      repeat (HALF) @(negedge clk); spi_sck = 0;
    end
    sel_off;
    rd1(7'h20, r); chk("R8 partial byte discarded", r, 8'h00);

    // R5: burst write and read, plus wrap at 0x7F
    sel_on; xbyte(8'h30, r, oa, ol);
    for (int i = 0; i < 4; i++) xbyte(8'h10 + 8'(i), r, oa, ol);
    sel_off;
    sel_on; xbyte(8'hB0, r, oa, ol);
    for (int i = 0; i < 4; i++) begin
      xbyte(8'h00, r, oa, ol);
      chk($sformatf("R5 burst read %0d", i), r, 8'h10 + 8'(i));
    end
    sel_off;
    sel_on; xbyte(8'h7F, r, oa, ol); xbyte(8'h11, r, oa, ol); xbyte(8'h22, r, oa, ol); sel_off;
    rd1(7'h00, r); chk("R5 wrap write to 0x00", r, 8'h22);
    sel_on; xbyte(8'hFF, r, oa, ol);
    xbyte(8'h00, r, oa, ol); chk("R5 wrap read 0x7F", r, 8'h11);
    xbyte(8'h00, r, oa, ol); chk("R5 wrap read 0x00", r, 8'h22);
    sel_off;

    // R4: FIFO port streams without address advance
    sel_on; xbyte(8'h7E, r, oa, ol);
    xbyte(8'hD1, r, oa, ol); xbyte(8'hD2, r, oa, ol); xbyte(8'hD3, r, oa, ol);
    sel_off;
    chk("R4 push count", push_cnt, 3);
    chk("R4 pushed bytes", {push_log[0], push_log[1], push_log[2]}, 24'hD1D2D3);
    rd1(7'h7F, r); chk("R4 0x7F not written by FIFO burst", r, 8'h11);
    chk("R4 no pop before FIFO read", pop_cnt, 0);
    sel_on; xbyte(8'hFE, r, oa, ol);
    for (int i = 0; i < 3; i++) begin
      xbyte(8'h00, r, oa, ol);
      chk($sformatf("R4 fifo read %0d", i), r, 8'hC0 + 8'(i));
    end
    sel_off;
    chk("R4 pop count", pop_cnt, 3);

    // R7: status pair stays consistent within one access
    stat_val = 16'h1234;
    sel_on; xbyte(8'h90, r, oa, ol);
    fork begin repeat (20) @(negedge clk); stat_val = 16'hABCD; end join_none
    xbyte(8'h00, r, oa, ol); xbyte(8'h00, r2, oa, ol);
    sel_off;
    chk("R7 status low byte", r, 8'h34);
    chk("R7 status high from shadow", r2, 8'h12);
    rd1(7'h11, r); chk("R7 lone high read returns shadow", r, 8'h12);
    wr1(7'h10, 8'hEE);
    rd1(7'h10, r); chk("R7 write to status ignored", r, 8'hCD);

    chk("R6 SDO stable while SCK high", unstable, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule